// File: doc/BRIEF.md
# Clocked Serial Byte Sender with Acknowledge Timeout

This block sends bytes to a partner receiver over two wires: a clock line it always drives, and a data line that both sides share. Bytes arrive on a ready/valid input. Each byte goes out as eight clock pulses, most significant bit first. The data is set up while the clock is low and held through the high phase. The receiver takes each bit on the falling edge of the clock.

After the eighth bit the sender stops driving the data line. It then waits for the receiver to pull the line low as an acknowledge. If no acknowledge comes within a set number of system clocks, the sender raises a sticky error flag and stops. To close a transfer, the user raises a finish request. The sender then transmits an all-ones byte. When that byte is acknowledged, the sender holds a completion flag and takes no more bytes until reset.

The data line is modelled as three signals: a level to drive, an output enable, and the resolved line level read back through a synchronizer. The line is released whenever the enable is low, and an external pull-up then holds it high.

Top module: `ser_byte_tx`

## Requirements
- R1: During and after reset, ready_o is high and these outputs are low: sclk_o, sdata_oe_o, busy_o, done_o and err_o.
- R2: Each accepted byte produces exactly eight high pulses on sclk_o. Bits go out most significant first, so a receiver that shifts left on each falling edge of sclk_o rebuilds the byte unchanged.
- R3: The data level is driven for at least HALF system clocks before each rising edge of sclk_o. It stays unchanged while sclk_o is high, and for the cycle in which sclk_o falls.
- R4: After the eighth falling edge, sdata_oe_o goes low and releases the line. busy_o stays high and ready_o stays low until the line is seen low (acknowledge) or the timeout expires.
- R5: ready_o is high only when all of these hold: the sender is idle, no error is flagged, the transfer is not complete, and finish_i is low. A byte is taken on a cycle with valid_i and ready_o both high. The next byte is taken only after the previous one has been acknowledged.
- R6: If the line is not seen low within TIMEOUT system clocks of the start of the wait, err_o rises and stays high until reset. After that, ready_o stays low, busy_o is low, and sclk_o does not pulse. A late acknowledge or a valid_i has no effect.
- R7: A high finish_i while the sender is idle starts the terminator byte 0xFF. finish_i takes priority over a pending valid_i, and that data byte is not taken.
- R8: Once the terminator is acknowledged, done_o rises and stays high until reset. ready_o then stays low, and sclk_o does not pulse again whatever valid_i does.
- R9: sclk_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i holds a byte |
| ready_o | output | 1 | A byte can be taken this cycle |
| finish_i | input | 1 | Request to send the all-ones terminator |
| sclk_o | output | 1 | Serial clock, active high |
| sdata_o | output | 1 | Level driven onto the data line |
| sdata_oe_o | output | 1 | Output enable for the data line |
| sdata_i | input | 1 | Resolved data line level, asynchronous |
| busy_o | output | 1 | A byte is being sent or is awaiting its acknowledge |
| done_o | output | 1 | Terminator acknowledged, transfer complete |
| err_o | output | 1 | Acknowledge timeout occurred |

## Verification
The bench feeds bytes with all zeros, a single set MSB, a single set LSB, alternating bits and all ones. A bit-order or bit-count slip would show up as a wrong byte at the receiver model. Setup and hold are measured at the pins at every clock edge. A design that changes data in the same cycle as the rising or falling clock would fail those measurements.

The bench samples ready_o while the line is released. A sender that takes a new byte before the acknowledge would show ready high there. The bench also raises finish_i and valid_i together. A design that gives data priority would transmit 0x55 where the scoreboard expects 0xFF.

For the timeout, the bench times the gap between the line release and err_o against TIMEOUT. It then pulls the line low late and holds valid_i high. A design whose error is not sticky, or that restarts after the error, would produce clock pulses there. The same valid_i probe after completion catches a sender that keeps running after the terminator.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACK  = 2'd2,
    ST_DONE = 2'd3
  } tx_state_e;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2
  } bit_phase_e;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] TERM_BYTE = '1;
endpackage

// File: rtl/ser_tx_sync.sv
module ser_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= 1'b1;
        else if (g == 0) pipe_q[g] <= d_i;
        else pipe_q[g] <= pipe_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_tx_bitgen.sv
module ser_tx_bitgen
  import ser_tx_pkg::*;
#(
  parameter int unsigned HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              done_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned IW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);
  localparam logic [IW-1:0] IDX_END = IW'(BYTE_W);

  bit_phase_e        phase_q;
  logic [IW-1:0]     idx_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              busy_q, sclk_q, data_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      idx_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      data_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          sh_q    <= byte_i;
          idx_q   <= '0;
          cnt_q   <= '0;
          phase_q <= PH_HOLD;
          sclk_q  <= 1'b0;
          data_q  <= 1'b1;
        end
      end else begin
        unique case (phase_q)
          // one cycle of hold after each falling edge
          PH_HOLD: begin
            if (idx_q == IDX_END) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              data_q  <= sh_q[BYTE_W-1];
              sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
              cnt_q   <= '0;
              phase_q <= PH_SETUP;
            end
          end
          PH_SETUP: begin
            if (cnt_q == CNT_LAST) begin
              sclk_q  <= 1'b1;
              cnt_q   <= '0;
              phase_q <= PH_HIGH;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_q == CNT_LAST) begin
              sclk_q  <= 1'b0;
              cnt_q   <= '0;
              idx_q   <= idx_q + 1'b1;
              phase_q <= PH_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: phase_q <= PH_HOLD;
        endcase
      end
    end
  end

  assign busy_o  = busy_q;
  assign sclk_o  = sclk_q;
  assign sdata_o = data_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ser_tx_ackwait.sv
module ser_tx_ackwait #(
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned BLANK   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic line_i,
  output logic ack_o,
  output logic tmo_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);
  localparam logic [TW-1:0] T_BLANK = TW'(BLANK);

  logic [TW-1:0] cnt_q;
  logic          act_q, ack_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      ack_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      tmo_q <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q) begin
        // blanking skips the synchronizer still holding our own last bit
        if (cnt_q >= T_BLANK && !line_i) begin
          ack_q <= 1'b1;
          act_q <= 1'b0;
        end else if (cnt_q == T_LAST) begin
          tmo_q <= 1'b1;
          act_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ack_o = ack_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/ser_byte_tx.sv
module ser_byte_tx
  import ser_tx_pkg::*;
#(
  parameter int unsigned HALF        = 4,
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              finish_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  input  logic              sdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned BLANK = SYNC_STAGES + 1;

  tx_state_e         state_q;
  logic              err_q, term_q;
  logic              idle_ok, start, ack_start;
  logic              bg_busy, bg_done, line_s, ack, tmo;
  logic [BYTE_W-1:0] tx_byte;

  assign idle_ok   = (state_q == ST_IDLE) && !err_q;
  assign start     = idle_ok && (finish_i || valid_i);
  assign tx_byte   = finish_i ? TERM_BYTE : data_i;
  assign ack_start = (state_q == ST_SEND) && bg_done;

  ser_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdata_i),
    .q_o   (line_s)
  );

  ser_tx_bitgen #(.HALF(HALF)) u_bitgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .byte_i (tx_byte),
    .busy_o (bg_busy),
    .sclk_o (sclk_o),
    .sdata_o(sdata_o),
    .done_o (bg_done)
  );

  ser_tx_ackwait #(.TIMEOUT(TIMEOUT), .BLANK(BLANK)) u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ack_start),
    .line_i (line_s),
    .ack_o  (ack),
    .tmo_o  (tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      term_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEND;
          term_q  <= finish_i;
        end
        ST_SEND: if (bg_done) state_q <= ST_ACK;
        ST_ACK: begin
          if (ack) state_q <= term_q ? ST_DONE : ST_IDLE;
          else if (tmo) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = idle_ok && !finish_i;
  assign sdata_oe_o = (state_q == ST_SEND) && bg_busy;
  assign busy_o     = (state_q == ST_SEND) || (state_q == ST_ACK);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
endmodule

// File: rtl/ser_byte_tx_chk.sv
module ser_byte_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_stable_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_hold_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdata_o));

  assert_driven_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> sdata_oe_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_no_clk_after_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!sclk_o && !ready_o && !busy_o));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !ready_o && !sclk_o));

  assert_ready_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !busy_o);

  assert_clk_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o);
endmodule

bind ser_byte_tx ser_byte_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .sclk_o    (sclk_o),
  .sdata_o   (sdata_o),
  .sdata_oe_o(sdata_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/ser_byte_tx_test.sv
module ser_byte_tx_test;
  localparam int HALF_T = 3;
  localparam int TMO_T  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0, finish = 1'b0, rx_pull = 1'b0;
  logic       ready_o, sclk_o, sdata_o, sdata_oe_o, busy_o, done_o, err_o;
  logic       line;

  int         n_cmp = 0, n_bad = 0, rise_cnt = 0;
  logic [7:0] exp_q[$];
  bit         ack_en = 1'b1;
  int         ack_dly = 4;

  always #5 clk = ~clk;
  assign line = sdata_oe_o ? sdata_o : ~rx_pull;

  ser_byte_tx #(.HALF(HALF_T), .TIMEOUT(TMO_T), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .ready_o(ready_o),
    .finish_i(finish), .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .sdata_i(line), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!ready_o) @(negedge clk);
    valid = 1'b1;
    data  = b;
    exp_q.push_back(b);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // pin-level setup/hold timing
  initial begin
    logic ps = 1'b0, last = 1'b1, hv = 1'b0;
    int   stab = 0;
    forever begin
      @(negedge clk);
      if (line !== last) stab = 0; else stab++;
      last = line;
      if (!ps && sclk_o) begin
        rise_cnt++;
        chk(stab >= HALF_T, "R3 setup before rise", stab, HALF_T);
        hv = line;
      end
      if (ps && !sclk_o) chk(line == hv, "R3 hold at fall", line, hv);
      ps = sclk_o;
    end
  end

  // receiver model and scoreboard monitor
  initial begin
    logic       ps = 1'b0;
    logic [7:0] sh = '0, e;
    int         nb = 0;
    forever begin
      @(negedge clk);
      if (ps && !sclk_o) begin
        sh = {sh[6:0], line};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", sh, 0);
          else begin
            e = exp_q.pop_front();
            chk(sh == e, "R2 received byte", sh, e);
          end
          while (sdata_oe_o) @(negedge clk);
          chk(!ready_o && busy_o, "R4 waiting for ack (ready,busy)", {ready_o, busy_o}, 1);
          if (ack_en) begin
            repeat (ack_dly) @(negedge clk);
            rx_pull = 1'b1;
            repeat (3) @(negedge clk);
            rx_pull = 1'b0;
          end
        end
      end
      ps = sclk_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int r0, cnt;
    repeat (3) @(negedge clk);
    chk(ready_o && !sclk_o && !sdata_oe_o && !busy_o && !done_o && !err_o,
        "R1 in reset", {ready_o, sclk_o, sdata_oe_o, busy_o, done_o, err_o}, 6'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o && !sclk_o && !sdata_oe_o && !busy_o && !done_o && !err_o,
        "R1 after reset", {ready_o, sclk_o, sdata_oe_o, busy_o, done_o, err_o}, 6'h20);

    // R2 R5: varied patterns, each waits for the previous ack
    send_byte(8'hA5);
    send_byte(8'h00);
    send_byte(8'h80);
    ack_dly = 10;
    send_byte(8'h01);
    send_byte(8'h3C);
    ack_dly = 1;
    send_byte(8'hFF);
    send_byte(8'h96);

    // R7: finish has priority over a pending byte
    while (!ready_o) @(negedge clk);
    valid  = 1'b1;
    data   = 8'h55;
    finish = 1'b1;
    exp_q.push_back(8'hFF);
    #1;
    chk(!ready_o, "R7 ready low while finish", ready_o, 0);
    @(negedge clk);
    valid  = 1'b0;
    finish = 1'b0;
    chk(busy_o, "R7 terminator started", busy_o, 1);

    cnt = 0;
    while (!done_o && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done_o, "R8 done after terminator ack", done_o, 1);
    chk(!ready_o && !err_o, "R8 ready low, no error", {ready_o, err_o}, 0);
    r0 = rise_cnt;
    valid = 1'b1;
    data  = 8'h77;
    repeat (60) @(negedge clk);
    valid = 1'b0;
    chk(rise_cnt == r0, "R8 no clock after done", rise_cnt - r0, 0);
    chk(done_o, "R8 done held", done_o, 1);
    chk(exp_q.size() == 0, "R7 data byte not sent", exp_q.size(), 0);

    // R6: timeout
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ack_en = 1'b0;
    @(negedge clk);
    chk(!done_o && ready_o, "R1 reset clears done", {done_o, ready_o}, 1);
    send_byte(8'h5A);
    while (!sdata_oe_o) @(negedge clk);
    while (sdata_oe_o) @(negedge clk);
    cnt = 0;
    while (!err_o && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= TMO_T && cnt <= TMO_T + 3, "R6 timeout delay", cnt, TMO_T);
    chk(!ready_o && !busy_o, "R6 stopped after error", {ready_o, busy_o}, 0);
    r0 = rise_cnt;
    rx_pull = 1'b1;
    valid   = 1'b1;
    data    = 8'h11;
    repeat (50) @(negedge clk);
    rx_pull = 1'b0;
    valid   = 1'b0;
    chk(err_o, "R6 error held", err_o, 1);
    chk(rise_cnt == r0, "R6 no clock after error", rise_cnt - r0, 0);
    chk(!done_o && !ready_o, "R6 late ack ignored", {done_o, ready_o}, 0);
    chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
    summary();
  end
endmodule